// File: doc/BRIEF.md
# I2C Slave Address Match Receiver

This block is the slave end of a two-wire serial bus. It watches already-synchronized clock and data lines and recognizes start and stop conditions. After a start it shifts the first byte into its data register. It then checks whether the top seven bits name this device. On a hit it pulls the data line low for the acknowledge clock and records the direction bit. From then on it either takes data bytes from the master or shifts bytes onto the bus, one acknowledge clock after every byte.

The system clock must run several times faster than the bus clock, because every bus event is seen as a change between two consecutive samples. The host presents the byte to send on `tx_byte`. It reads received bytes from `rx_byte` when `rx_valid` pulses.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, `busy`, `addressed`, `transmit` and `rx_valid` are 0, `rx_byte` is 0, and `sda_drive_low` is 0 (line released).
- R2: A start condition (SDA falling while SCL is high) sets `busy` and clears `transmit` and `addressed`.
- R3: After a start, each SCL rising edge shifts the sampled SDA level into bit 0 of `rx_byte`, so after eight pulses `rx_byte` holds the address byte with its first bit in bit 7.
- R4: When `rx_byte[7:1]` equals `own_addr` after the eighth pulse, `addressed` is set and SDA is held low from the following SCL fall until the SCL fall that ends the ninth pulse.
- R5: On an address match, `transmit` takes `rx_byte[0]` (1 = the slave sends data, 0 = the slave receives data).
- R6: On an address mismatch, SDA is not pulled low on the ninth pulse. Later bytes are neither stored nor acknowledged until the next start.
- R7: When receiving, each further byte is shifted into `rx_byte` and acknowledged on its ninth pulse. `rx_valid` pulses for one clock once per byte.
- R8: When transmitting, `tx_byte` is captured at the end of each acknowledge pulse and sent with its first bit in bit 7. SDA drive changes only while SCL is low, and the line is released for the master's acknowledge pulse.
- R9: A high level sampled on the ninth pulse of a transmitted byte (master not-acknowledge) ends transmission. SDA stays released until the next start.
- R10: A stop condition (SDA rising while SCL is high) clears `busy` and `addressed`.
- R11: A repeated start during a transfer restarts address reception, and a matching address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data level |
| own_addr | input | 7 | This device's 7-bit address |
| tx_byte | input | 8 | Byte to send when addressed for reading |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_byte | output | 8 | Data register holding shifted-in bits |
| busy | output | 1 | Bus busy flag |
| addressed | output | 1 | Addressed-as-slave flag |
| transmit | output | 1 | Direction flag, 1 when the slave sends |
| rx_valid | output | 1 | One-clock pulse when a received data byte is complete |

## Verification
The assertions assume a well-formed bus. SDA only moves while SCL is high at a start or a stop. Each SCL level is held for at least two system clocks. No start or stop is attempted while the slave holds SDA low, which is what a wired-AND line would cause. The bench builds the bus level as the master's drive ANDed with the slave's release. It holds every SCL phase for eight clocks and changes master data only in the low phase, so it stays inside these assumptions.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr,
  input  logic [7:0] tx_byte,
  output logic       sda_drive_low,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       addressed,
  output logic       transmit,
  output logic       rx_valid
);

  localparam int BITS = 8;
  localparam logic [3:0] LAST = 4'(BITS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_SKIP} st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh;

  wire scl_hi   = scl_in & scl_q;
  wire start_c  = scl_hi & sda_q & ~sda_in;
  wire stop_c   = scl_hi & ~sda_q & sda_in;
  wire scl_rise = scl_in & ~scl_q;
  wire scl_fall = ~scl_in & scl_q;
  wire hit      = (rx_byte[7:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt <= '0;
      sh <= '0;
      rx_byte <= '0;
      busy <= 1'b0;
      addressed <= 1'b0;
      transmit <= 1'b0;
      rx_valid <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      rx_valid <= 1'b0;
      if (start_c) begin
        busy <= 1'b1;
        transmit <= 1'b0;
        addressed <= 1'b0;
        cnt <= '0;
        sda_drive_low <= 1'b0;
        st <= S_ADDR;
      end else if (stop_c) begin
        busy <= 1'b0;
        addressed <= 1'b0;
        sda_drive_low <= 1'b0;
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt != LAST) begin
              rx_byte <= {rx_byte[6:0], sda_in};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST) begin
              if (st == S_RX) begin
                sda_drive_low <= 1'b1;
                rx_valid <= 1'b1;
                st <= S_RACK;
              end else if (hit) begin
                addressed <= 1'b1;
                transmit <= rx_byte[0];
                sda_drive_low <= 1'b1;
                st <= S_AACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (transmit) begin
                sh <= tx_byte;
                sda_drive_low <= ~tx_byte[7];
                st <= S_TX;
              end else begin
                sda_drive_low <= 1'b0;
                st <= S_RX;
              end
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              cnt <= '0;
              st <= S_RX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_drive_low <= 1'b0;
                st <= S_TACK;
              end else begin
                sda_drive_low <= ~sh[3'd7 - cnt[2:0]];
              end
            end
          end
          S_TACK: begin
            if (scl_rise && sda_in) begin
              st <= S_SKIP;
            end else if (scl_fall) begin
              sh <= tx_byte;
              sda_drive_low <= ~tx_byte[7];
              cnt <= '0;
              st <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (busy && !transmit && !addressed));

  // R10
  stop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!busy && !addressed));

  // R8
  scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi |-> $stable(sda_drive_low));

  // R4
  match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> sda_drive_low);

  // R6
  skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_drive_low);

  // R7
  rx_valid_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (sda_drive_low && !transmit));

endmodule

// File: tb/test_i2c_addr_slave.sv
module test_i2c_addr_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [6:0] own_addr = 7'h3A;
  logic [7:0] tx_byte = 8'h00;
  logic sda_drive_low, busy, addressed, transmit, rx_valid;
  logic [7:0] rx_byte;
  wire sda_bus = m_sda & ~sda_drive_low;

  int runs = 0, fails = 0, rxv_cnt = 0, viol = 0;
  bit done = 0;
  logic scl_p = 1'b1, drv_p = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_slave i_i2c_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_drive_low(sda_drive_low),
    .rx_byte(rx_byte), .busy(busy), .addressed(addressed),
    .transmit(transmit), .rx_valid(rx_valid));

  always @(posedge clk) begin
    if (rx_valid) rxv_cnt++;
    if (rst_n && scl && scl_p && sda_drive_low != drv_p) viol++;
    scl_p <= scl;
    drv_p <= sda_drive_low;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; gap();
    scl = 1'b1; gap();
    m_sda = 1'b0; gap();
    scl = 1'b0; gap();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; gap();
    scl = 1'b1; gap();
    m_sda = 1'b1; gap();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; gap();
    scl = 1'b1; gap();
    s = sda_bus; gap();
    scl = 1'b0; gap();
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
  endtask

  task automatic t_reset();
    check(!busy && !addressed && !transmit && !rx_valid, "R1 flags", {busy, addressed, transmit, rx_valid}, 0);
    check(rx_byte == 8'h00 && !sda_drive_low, "R1 data/line", {rx_byte, sda_drive_low}, 0);
  endtask

  task automatic t_write();
    logic s;
    int c0;
    bus_start();
    check(busy && !transmit && !addressed, "R2 start flags", {busy, transmit, addressed}, 3'b100);
    send_byte(8'h74);
    check(rx_byte == 8'h74, "R3 address shift", rx_byte, 8'h74);
    clock_bit(1'b1, s);
    check(s == 1'b0, "R4 address ack", s, 0);
    check(addressed == 1'b1, "R4 addressed", addressed, 1);
    check(transmit == 1'b0, "R5 write dir", transmit, 0);
    c0 = rxv_cnt;
    send_byte(8'hA5);
    clock_bit(1'b1, s);
    check(s == 1'b0 && rx_byte == 8'hA5, "R7 byte1", {s, rx_byte}, 9'h0A5);
    send_byte(8'h3C);
    clock_bit(1'b1, s);
    check(s == 1'b0 && rx_byte == 8'h3C, "R7 byte2", {s, rx_byte}, 9'h03C);
    check(rxv_cnt - c0 == 2, "R7 rx_valid pulses", rxv_cnt - c0, 2);
    bus_stop();
    check(!busy && !addressed, "R10 stop", {busy, addressed}, 0);
  endtask

  task automatic t_mismatch();
    logic s;
    bus_start();
    send_byte(8'h20);
    clock_bit(1'b1, s);
    check(s == 1'b1 && !addressed, "R6 no ack", {s, addressed}, 2'b10);
    send_byte(8'hFF);
    clock_bit(1'b1, s);
    check(s == 1'b1 && rx_byte == 8'h20, "R6 ignored byte", {s, rx_byte}, 9'h120);
    bus_stop();
  endtask

  task automatic t_read();
    logic s;
    logic [7:0] v;
    tx_byte = 8'hC6;
    bus_start();
    send_byte(8'h75);
    clock_bit(1'b1, s);
    check(s == 1'b0 && transmit, "R5 read dir", {s, transmit}, 2'b01);
    read_byte(v);
    check(v == 8'hC6, "R8 byte1", v, 8'hC6);
    tx_byte = 8'h39;
    clock_bit(1'b0, s);
    read_byte(v);
    check(v == 8'h39, "R8 byte2", v, 8'h39);
    check(viol == 0, "R8 stable while SCL high", viol, 0);
    clock_bit(1'b1, s);
    read_byte(v);
    check(v == 8'hFF && !sda_drive_low, "R9 after nack", v, 8'hFF);
    bus_start();
    check(busy && !transmit && !addressed, "R2 repeated start", {busy, transmit, addressed}, 3'b100);
    send_byte(8'h74);
    clock_bit(1'b1, s);
    check(s == 1'b0 && addressed, "R11 re-addressed", {s, addressed}, 2'b01);
    bus_stop();
    check(!busy && !addressed, "R10 stop after read", {busy, addressed}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule